// File: doc/BRIEF.md
# SPI Flash Host with Linear Data Buffer

This block is a serial-flash host controller. Software reaches it through a byte-wide register bus. A transfer is set up by writing an opcode, a transmit byte count and a receive byte count, and by filling a directly addressed 71-byte data buffer from its first location upward. Setting the execute bit then starts the transfer. The engine lowers chip select and shifts out the opcode, then the transmit bytes taken from the buffer in order. After those it clocks in the requested number of response bytes.

Each response byte goes into the buffer at the position that follows the transmit bytes, and the position wraps to the start of the buffer when it passes the last location. Software therefore finds the reply right behind the data it sent. A 16-bit speed register holds four 4-bit clock selectors. In this block only the normal-speed selector sets the serial clock rate. A separate enable bit gates whether the execute bit has any effect.

Top module: `spi_linbuf_host`

## Requirements
- R1: After reset every register and every buffer location reads 0x00, `cs_n` is high and `sclk` is low.
- R2: Register decode: the opcode is at 0x00. Bit 0 of 0x02 is execute when written and busy when read. Bit 0 of 0x20 is the enable and reads back as written, with its other bits reading 0. The speed word is split across two bytes: 0x22 holds the alternate selector in [7:4] and the TPM selector in [3:0], and 0x23 holds the normal selector in [7:4] and the fast selector in [3:0]. The transmit count is at 0x48 and the receive count at 0x4B. The buffer occupies 0x80 to 0xC6, with buffer index n at 0x80+n. Every other address reads 0x00.
- R3: A write of a value above 68 to either count register stores 68.
- R4: Writing 1 to bit 0 of 0x02 while the enable is 1 and no transfer is running starts a transfer. Offset 0x02 then reads 0x01 until the transfer ends and 0x00 afterwards. The same write with the enable at 0 starts nothing.
- R5: During a transfer `cs_n` stays low throughout and SPI mode 0 is used, MSB first, with `mosi` stable while `sclk` is high. The frame is the opcode, then buffer bytes 0 to txcount-1, then rxcount bytes during which `mosi` is 0. That makes exactly 8*(1+txcount+rxcount) rising `sclk` edges.
- R6: Receive byte i is stored at buffer index (txcount+i) mod 71. Every other buffer location keeps its contents.
- R7: With a receive count of 0, the transfer ends after the last transmit byte.
- R8: The normal selector sets the `sclk` half period in system clocks. Code 4 gives 1, code 0 gives 2, code 1 gives 3, code 2 gives 4, code 3 gives 6 and code 7 gives SLOW_HALF (125 by default). Every other code falls back to SLOW_HALF. The `sclk` period is twice the half period.
- R9: Bus writes to any register or buffer location are ignored while a transfer is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 8 | Register bus byte address |
| bus_wdata | input | 8 | Register bus write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| miso | input | 1 | Serial data from the flash |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the flash |

## Verification
Suppose the buffer pointer slips or fails to wrap. The fault would appear as shifted data in the transmitted frame, or as reply bytes landing at the wrong buffer index. Both show up on the first transfer whose transmit and receive counts together exceed 71, and the buffer read-back after that transfer exposes them. A byte counter off by one changes the number of `sclk` edges while `cs_n` is low, so it shows on any transfer, and the case with no receive bytes catches an extra trailing byte. A wrong divider mapping changes the measured `sclk` period on the first two clock edges of a transfer. A missing write lock during a transfer shows on the next read-back of the opcode and count registers.

// File: rtl/spi_lb_pkg.sv
// Shared register offsets for the linear-buffer SPI host.
// Assumes a byte-wide bus and a buffer base on a 128-byte boundary.
package spi_lb_pkg;
    localparam logic [7:0] A_OPCODE = 8'h00;
    localparam logic [7:0] A_CTRL   = 8'h02;
    localparam logic [7:0] A_ENABLE = 8'h20;
    localparam logic [7:0] A_SPD_LO = 8'h22;
    localparam logic [7:0] A_SPD_HI = 8'h23;
    localparam logic [7:0] A_TXCNT  = 8'h48;
    localparam logic [7:0] A_RXCNT  = 8'h4B;
endpackage

// File: rtl/spi_lb_regs.sv
// Register file and data buffer. It decodes bus reads and writes, clamps the
// counts and blocks bus writes while the engine is busy. The engine owns the
// buffer write port during a transfer.
// Assumes DEPTH <= 128, so that the buffer fits in 0x80..0xFF.
module spi_lb_regs
    import spi_lb_pkg::*;
#(
    parameter int DEPTH = 71,
    parameter int MAXC  = 68,
    parameter int IW    = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    bus_addr,
    input  logic [7:0]    bus_wdata,
    input  logic          bus_we,
    output logic [7:0]    bus_rdata,
    input  logic          busy,
    output logic          start,
    output logic [7:0]    opcode,
    output logic [7:0]    txcnt,
    output logic [7:0]    rxcnt,
    output logic [3:0]    spd_norm,
    input  logic [IW-1:0] rd_idx,
    output logic [7:0]    buf_rd,
    input  logic          rx_we,
    input  logic [IW-1:0] rx_idx,
    input  logic [7:0]    rx_data
);
    localparam logic [7:0]    MAXB  = 8'(MAXC);
    localparam logic [IW-1:0] DLAST = IW'(DEPTH - 1);

    logic [7:0]    mem [DEPTH];
    logic          enable;
    logic [15:0]   speed;
    logic          in_buf;
    logic [IW-1:0] bidx;
    logic [7:0]    wcap;

    assign bidx     = bus_addr[IW-1:0];
    assign in_buf   = bus_addr[7] && (bus_addr[6:0] <= 7'(DEPTH - 1)) && (bidx <= DLAST);
    assign wcap     = (bus_wdata > MAXB) ? MAXB : bus_wdata;
    assign spd_norm = speed[15:12];
    assign start    = bus_we && (bus_addr == A_CTRL) && bus_wdata[0] && enable && !busy;
    assign buf_rd   = mem[rd_idx];

    // Register and buffer updates from the bus (idle) or the engine (busy).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opcode <= '0;
            enable <= 1'b0;
            speed  <= '0;
            txcnt  <= '0;
            rxcnt  <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (busy) begin
            if (rx_we) mem[rx_idx] <= rx_data;
        end else if (bus_we) begin
            case (bus_addr)
                A_OPCODE: opcode      <= bus_wdata;
                A_ENABLE: enable      <= bus_wdata[0];
                A_SPD_LO: speed[7:0]  <= bus_wdata;
                A_SPD_HI: speed[15:8] <= bus_wdata;
                A_TXCNT:  txcnt       <= wcap;
                A_RXCNT:  rxcnt       <= wcap;
                default:  if (in_buf) mem[bidx] <= bus_wdata;
            endcase
        end
    end

    // Read-data multiplexer.
    always_comb begin
        case (bus_addr)
            A_OPCODE: bus_rdata = opcode;
            A_CTRL:   bus_rdata = {7'b0, busy};
            A_ENABLE: bus_rdata = {7'b0, enable};
            A_SPD_LO: bus_rdata = speed[7:0];
            A_SPD_HI: bus_rdata = speed[15:8];
            A_TXCNT:  bus_rdata = txcnt;
            A_RXCNT:  bus_rdata = rxcnt;
            default:  bus_rdata = in_buf ? mem[bidx] : 8'h00;
        endcase
    end
endmodule

// File: rtl/spi_lb_clkdiv.sv
// Serial clock divider. It maps a 4-bit speed code to a half period in system
// clocks and pulses tick once per half period while run is high.
// Assumes SLOW_HALF >= 6.
module spi_lb_clkdiv #(
    parameter int SLOW_HALF = 125,
    parameter int HW        = $clog2(SLOW_HALF + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [3:0] code,
    output logic       tick
);
    logic [HW-1:0] half;
    logic [HW-1:0] hcnt;

    // Code-to-half-period map; reserved codes take the slowest rate.
    always_comb begin
        case (code)
            4'd4:    half = HW'(1);
            4'd0:    half = HW'(2);
            4'd1:    half = HW'(3);
            4'd2:    half = HW'(4);
            4'd3:    half = HW'(6);
            default: half = HW'(SLOW_HALF);
        endcase
    end

    assign tick = run && (hcnt == half - HW'(1));

    // Half-period counter, cleared while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) hcnt <= '0;
        else                        hcnt <= hcnt + HW'(1);
    end
endmodule

// File: rtl/spi_lb_engine.sv
// Shift engine. It runs one mode-0, MSB-first frame: the opcode, then txcnt
// buffer bytes, then rxcnt response bytes written back at the running buffer
// index, which wraps at DEPTH. Buffer index for frame byte k (k >= 1) is k-1.
// Assumes txcnt + rxcnt <= 255 and that the counts are stable while idle.
module spi_lb_engine #(
    parameter int DEPTH = 71,
    parameter int IW    = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [7:0]    opcode,
    input  logic [7:0]    txcnt,
    input  logic [7:0]    rxcnt,
    input  logic          tick,
    input  logic [7:0]    buf_rd,
    input  logic          miso,
    output logic [IW-1:0] rd_idx,
    output logic          rx_we,
    output logic [IW-1:0] rx_idx,
    output logic [7:0]    rx_data,
    output logic          busy,
    output logic          cs_n,
    output logic          sclk,
    output logic          mosi
);
    localparam logic [IW-1:0] LAST_IDX = IW'(DEPTH - 1);

    logic [2:0]    bitn;
    logic [7:0]    byten, tx_l, rx_l, txsh, rxsh;
    logic [IW-1:0] ptr, ptr_nxt;
    logic          last_byte, byte_end;

    // Buffer index of the next frame byte.
    always_comb begin
        if (byten == 8'd0)         ptr_nxt = '0;
        else if (ptr == LAST_IDX)  ptr_nxt = '0;
        else                       ptr_nxt = ptr + IW'(1);
    end

    assign last_byte = ({1'b0, byten} == ({1'b0, tx_l} + {1'b0, rx_l}));
    assign byte_end  = busy && tick && sclk && (bitn == 3'd7);
    assign rx_we     = byte_end && (byten > tx_l);
    assign rx_idx    = ptr;
    assign rx_data   = rxsh;
    assign rd_idx    = ptr_nxt;
    assign mosi      = busy && txsh[7];

    // Frame sequencing: start, rising-edge sample, falling-edge shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cs_n  <= 1'b1;
            sclk  <= 1'b0;
            bitn  <= '0;
            byten <= '0;
            tx_l  <= '0;
            rx_l  <= '0;
            txsh  <= '0;
            rxsh  <= '0;
            ptr   <= '0;
        end else if (!busy) begin
            if (start) begin
                busy  <= 1'b1;
                cs_n  <= 1'b0;
                sclk  <= 1'b0;
                txsh  <= opcode;
                bitn  <= '0;
                byten <= '0;
                ptr   <= '0;
                tx_l  <= txcnt;
                rx_l  <= rxcnt;
            end
        end else if (tick) begin
            if (!sclk) begin
                sclk <= 1'b1;
                rxsh <= {rxsh[6:0], miso};
            end else begin
                sclk <= 1'b0;
                if (bitn == 3'd7) begin
                    if (last_byte) begin
                        busy <= 1'b0;
                        cs_n <= 1'b1;
                    end else begin
                        byten <= byten + 8'd1;
                        bitn  <= '0;
                        ptr   <= ptr_nxt;
                        txsh  <= (byten < tx_l) ? buf_rd : 8'h00;
                    end
                end else begin
                    bitn <= bitn + 3'd1;
                    txsh <= {txsh[6:0], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/spi_linbuf_host.sv
// Top of the linear-buffer SPI flash host. It ties the register file, the
// clock divider and the shift engine together.
// Assumes BUF_DEPTH <= 128 and SLOW_HALF >= 6.
module spi_linbuf_host #(
    parameter int BUF_DEPTH = 71,
    parameter int SLOW_HALF = 125
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    input  logic       bus_we,
    output logic [7:0] bus_rdata,
    input  logic       miso,
    output logic       sclk,
    output logic       cs_n,
    output logic       mosi
);
    localparam int MAX_CNT = BUF_DEPTH - 3;
    localparam int IW      = $clog2(BUF_DEPTH);

    logic          eng_busy, start, tick, rx_we;
    logic [7:0]    opcode, txcnt, rxcnt, buf_rd, rx_data;
    logic [3:0]    spd_norm;
    logic [IW-1:0] rd_idx, rx_idx;

    spi_lb_regs #(.DEPTH(BUF_DEPTH), .MAXC(MAX_CNT), .IW(IW)) i_regs (
        .clk, .rst_n, .bus_addr, .bus_wdata, .bus_we, .bus_rdata,
        .busy(eng_busy), .start, .opcode, .txcnt, .rxcnt, .spd_norm,
        .rd_idx, .buf_rd, .rx_we, .rx_idx, .rx_data
    );

    spi_lb_clkdiv #(.SLOW_HALF(SLOW_HALF)) i_div (
        .clk, .rst_n, .run(eng_busy), .code(spd_norm), .tick
    );

    spi_lb_engine #(.DEPTH(BUF_DEPTH), .IW(IW)) i_eng (
        .clk, .rst_n, .start, .opcode, .txcnt, .rxcnt, .tick, .buf_rd, .miso,
        .rd_idx, .rx_we, .rx_idx, .rx_data, .busy(eng_busy), .cs_n, .sclk, .mosi
    );
endmodule

// File: rtl/spi_lb_checker.sv
// Protocol and state checks for spi_linbuf_host, attached with bind.
module spi_lb_checker #(
    parameter int DEPTH = 71,
    parameter int MAXC  = 68,
    parameter int IW    = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_we,
    input logic          busy,
    input logic          cs_n,
    input logic          sclk,
    input logic          mosi,
    input logic [7:0]    opcode,
    input logic [7:0]    txcnt,
    input logic [7:0]    rxcnt,
    input logic          rx_we,
    input logic [IW-1:0] rx_idx
);
    // R5
    idle_sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);
    // R4
    busy_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy == !cs_n);
    // R5
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));
    // R9
    locked_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_we) |=> ($stable(opcode) && $stable(txcnt) && $stable(rxcnt)));
    // R3
    count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txcnt <= 8'(MAXC)) && (rxcnt <= 8'(MAXC)));
    // R6
    rx_index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_we |-> (busy && (32'(rx_idx) < DEPTH)));
endmodule

bind spi_linbuf_host spi_lb_checker #(.DEPTH(BUF_DEPTH), .MAXC(MAX_CNT), .IW(IW)) i_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .busy(eng_busy), .cs_n(cs_n),
    .sclk(sclk), .mosi(mosi), .opcode(opcode), .txcnt(txcnt), .rxcnt(rxcnt),
    .rx_we(rx_we), .rx_idx(rx_idx)
);

// File: tb/test_spi_linbuf_host.sv
module test_spi_linbuf_host;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 71;
    localparam int MAXC       = 68;
    localparam int SLOW       = 125;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata;
    logic       miso, sclk, cs_n, mosi;

    logic [7:0] model [DEPTH];
    logic [7:0] resp  [140];
    logic [7:0] cap   [140];
    int         bitpos = 0;
    longint     t1 = 0, t2 = 0;
    int         nchk = 0, nfail = 0, cyc = 0;
    bit         done = 0;

    spi_linbuf_host i_spi_linbuf_host (
        .clk, .rst_n, .bus_addr, .bus_wdata, .bus_we, .bus_rdata,
        .miso, .sclk, .cs_n, .mosi
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Flash model: shifts response bits out, captures mosi on rising sclk.
    assign miso = resp[(bitpos / 8) % 140][7 - (bitpos % 8)];
    always @(posedge sclk or negedge cs_n) begin
        if (!sclk) begin
            bitpos = 0;
        end else if (!cs_n) begin
            cap[(bitpos / 8) % 140][7 - (bitpos % 8)] = mosi;
            if (bitpos == 0) t1 = $time;
            else if (bitpos == 1) t2 = $time;
            bitpos = bitpos + 1;
        end
    end

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        end
    endtask

    // Watchdog: an expired run counts as one failed check.
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 190000) begin
            nchk = nchk + 1;
            nfail = nfail + 1;
            $display("FAIL R4 watchdog actual=%0d expected<190000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nchk = nchk + 1;
        if (!ok) begin
            nfail = nfail + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic int exp_half(input logic [3:0] c);
        case (c)
            4'd4: return 1;
            4'd0: return 2;
            4'd1: return 3;
            4'd2: return 4;
            4'd3: return 6;
            default: return SLOW;
        endcase
    endfunction

    task automatic wait_idle();
        logic [7:0] d;
        int n = 0;
        d = 8'h01;
        while (d != 8'h00 && n < 40000) begin
            bus_read(8'h02, d);
            n++;
        end
        chk(d == 8'h00, "R4 busy clears", d, 0);
    endtask

    // One full transfer with checks on the frame and on the buffer contents.
    task automatic run_xfer(input logic [7:0] op, input int tx, input int rx, input bit poke);
        logic [7:0] d;
        int bad, ea, ee;
        bus_write(8'h00, op);
        bus_write(8'h48, 8'(tx));
        bus_write(8'h4B, 8'(rx));
        for (int n = 0; n < tx; n++) begin
            d = 8'($urandom);
            bus_write(8'h80 + 8'(n), d);
            model[n] = d;
        end
        for (int k = 0; k < 140; k++) begin resp[k] = 8'($urandom); cap[k] = 8'hXX; end
        bus_write(8'h02, 8'h01);
        bus_read(8'h02, d);
        chk(d == 8'h01, "R4 busy after execute", d, 1);
        if (poke) begin
            bus_write(8'h00, ~op);
            bus_write(8'h48, 8'd3);
            bus_write(8'h80, 8'h5A);
        end
        wait_idle();
        chk(cs_n == 1'b1, "R4 cs_n high after end", cs_n, 1);
        chk(bitpos == 8 * (1 + tx + rx), (rx == 0) ? "R7 edge count" : "R5 edge count",
            bitpos, 8 * (1 + tx + rx));
        chk(cap[0] == op, "R5 opcode on mosi", cap[0], op);
        bad = 0; ea = 0; ee = 0;
        for (int n = 0; n < tx; n++)
            if (cap[1 + n] !== model[n] && bad == 0) begin bad = 1; ea = cap[1 + n]; ee = model[n]; end
        for (int i = 0; i < rx; i++)
            if (cap[1 + tx + i] !== 8'h00 && bad == 0) begin bad = 1; ea = cap[1 + tx + i]; ee = 0; end
        chk(bad == 0, "R5 mosi frame data", ea, ee);
        for (int i = 0; i < rx; i++) model[(tx + i) % DEPTH] = resp[1 + tx + i];
        bad = 0;
        for (int n = 0; n < DEPTH; n++) begin
            bus_read(8'h80 + 8'(n), d);
            if (d !== model[n] && bad == 0) begin bad = 1; ea = d; ee = model[n]; end
        end
        chk(bad == 0, "R6 buffer after transfer", ea, ee);
        if (poke) begin
            bus_read(8'h00, d);
            chk(d == op, "R9 opcode locked", d, op);
            bus_read(8'h48, d);
            chk(d == 8'(tx), "R9 txcount locked", d, tx);
        end
    endtask

    initial begin
        logic [7:0] d;
        int bad;
        void'($urandom(32'h5EED));
        for (int n = 0; n < DEPTH; n++) model[n] = 8'h00;
        for (int k = 0; k < 140; k++) resp[k] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk(cs_n == 1'b1 && sclk == 1'b0, "R1 pins after reset", {cs_n, sclk}, 2);
        bad = 0;
        foreach (model[n]) begin
            bus_read(8'h80 + 8'(n), d);
            if (d != 8'h00) bad++;
        end
        chk(bad == 0, "R1 buffer zero", bad, 0);
        bad = 0;
        for (int k = 0; k < 7; k++) begin
            bus_read((k == 0) ? 8'h00 : (k == 1) ? 8'h02 : (k == 2) ? 8'h20 :
                     (k == 3) ? 8'h22 : (k == 4) ? 8'h23 : (k == 5) ? 8'h48 : 8'h4B, d);
            if (d != 8'h00) bad++;
        end
        chk(bad == 0, "R1 registers zero", bad, 0);

        // R4 execute ignored while disabled
        bus_write(8'h02, 8'h01);
        bus_read(8'h02, d);
        chk(d == 8'h00 && cs_n, "R4 execute with enable 0", d, 0);

        // R2 decode and read-back
        bus_write(8'h20, 8'hFF);
        bus_read(8'h20, d);
        chk(d == 8'h01, "R2 enable read-back", d, 1);
        bus_write(8'h22, 8'hA5);
        bus_write(8'h23, 8'h3C);
        bus_read(8'h22, d);
        chk(d == 8'hA5, "R2 speed low byte", d, 8'hA5);
        bus_read(8'h23, d);
        chk(d == 8'h3C, "R2 speed high byte", d, 8'h3C);
        bus_write(8'hC7, 8'h77);
        bus_write(8'h10, 8'h77);
        bus_read(8'hC7, d);
        chk(d == 8'h00, "R2 past buffer end", d, 0);
        bus_read(8'h10, d);
        chk(d == 8'h00, "R2 unmapped address", d, 0);
        bus_write(8'hC6, 8'h99);
        bus_read(8'hC6, d);
        chk(d == 8'h99, "R2 last buffer byte", d, 8'h99);
        model[70] = 8'h99;

        // R3 count clamp
        bus_write(8'h48, 8'h90);
        bus_read(8'h48, d);
        chk(d == 8'd68, "R3 txcount clamp", d, 68);
        bus_write(8'h4B, 8'd69);
        bus_read(8'h4B, d);
        chk(d == 8'd68, "R3 rxcount clamp", d, 68);
        bus_write(8'h4B, 8'd68);
        bus_read(8'h4B, d);
        chk(d == 8'd68, "R3 rxcount at limit", d, 68);

        // Directed transfers at the fastest rate
        bus_write(8'h23, 8'h40);
        run_xfer(8'h9F, 0, 3, 0);
        run_xfer(8'h02, 5, 0, 0);      // R7 no receive phase
        run_xfer(8'h03, 68, 68, 0);    // R6 wrap past index 70
        run_xfer(8'h0B, 1, 1, 0);

        // Constrained random transfers
        for (int t = 0; t < 12; t++)
            run_xfer(8'($urandom), int'($urandom % 69), int'($urandom % 69), 0);

        // R9 writes during a transfer are ignored
        bus_write(8'h23, 8'h30);
        run_xfer(8'hAB, 2, 2, 1);

        // R8 divider mapping, measured on the first sclk period
        for (int k = 0; k < 8; k++) begin
            logic [3:0] c;
            c = (k == 0) ? 4'd4 : (k == 1) ? 4'd0 : (k == 2) ? 4'd1 : (k == 3) ? 4'd2 :
                (k == 4) ? 4'd3 : (k == 5) ? 4'd7 : (k == 6) ? 4'd5 : 4'd12;
            bus_write(8'h23, {c, 4'h0});
            run_xfer(8'h05, 0, 1, 0);
            chk((t2 - t1) / CLK_PERIOD == longint'(2 * exp_half(c)), "R8 sclk period",
                (t2 - t1) / CLK_PERIOD, 2 * exp_half(c));
        end

        summary();
        $finish;
    end
endmodule